// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit virtual address into a 52-bit physical address by walking a four-level table tree held in memory. A requester hands it an address together with the page number of the top-level table. The walker then reads one 8-byte entry per level over a request/response memory port. Each table holds 512 entries and fills exactly one 4 KiB page.

The walk stops at the first leaf entry. A leaf in the second level maps a 1 GiB page, a leaf in the third level maps a 2 MiB page, and a valid entry in the bottom level maps a 4 KiB page. The walker reports the result to the TLB fill logic as a one-cycle pulse. The pulse carries the frame page number, a page-size code, the composed physical address and a fault flag.

The walker handles one walk at a time. It takes a new request only while idle, and at most one memory read is outstanding.

Top module: `pt_walk_top`

## Requirements
- R1: After a synchronous active-low reset, `req_ready_o` is 1, `mem_req_valid_o` is 0 and `done_valid_o` is 0.
- R2: A request whose virtual address bits [63:48] do not all equal bit 47 is accepted and produces no memory read. It completes with `done_fault_o`=1 on the cycle after acceptance.
- R3: The first read goes to {root page number, VA[47:39], 3'b000}. Each later read goes to {next-table page number, index, 3'b000}, where the index is VA[38:30], VA[29:21] and VA[20:12] for the second, third and fourth levels. Every read address therefore has bits [2:0] equal to zero.
- R4: `mem_req_valid_o` stays high with a stable address until `mem_req_ready_i` is seen high. No new request is raised before `mem_rsp_valid_i` returns the entry.
- R5: Entry format: bit 0 is valid, bit 7 is the leaf flag, and bits [51:12] hold the next-table or frame page number. A valid entry with bit 7 clear in the top three levels makes the walk descend to the table it names.
- R6: The size code on `done_size_o` is 2 for a leaf in the second level (1 GiB), 1 for a leaf in the third level (2 MiB) and 0 for any valid bottom-level entry (4 KiB), whatever its bit 7. `done_pa_o` is the frame base with the low 30, 21 or 12 bits taken from the VA.
- R7: An entry with bit 0 clear at any level faults the walk. A top-level entry with the leaf flag set also faults the walk.
- R8: A 1 GiB frame whose page number has any of bits [17:0] set faults the walk. So does a 2 MiB frame whose page number has any of bits [8:0] set.
- R9: `done_valid_o` is a single-cycle pulse, and the walker is idle again on the next cycle. While a walk runs, `req_ready_o` is 0 and requests are ignored. On a fault, `done_pa_o`, `done_ppn_o` and `done_size_o` are zero.
- R10: On a successful walk, `done_ppn_o` equals bits [51:12] of the leaf entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request taken this cycle |
| req_va_i | input | 64 | Virtual address to translate |
| root_ppn_i | input | 40 | Page number of the top-level table |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 52 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Entry data valid (one cycle) |
| mem_rsp_data_i | input | 64 | Entry read from memory |
| done_valid_o | output | 1 | Walk result pulse |
| done_fault_o | output | 1 | Walk faulted |
| done_size_o | output | 2 | Page size code: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| done_ppn_o | output | 40 | Frame page number |
| done_pa_o | output | 52 | Translated physical address |

## Verification
The assertions assume the memory returns exactly one response pulse for each accepted read, and never sends a response while no read is outstanding. The bench memory model keeps to this rule. It accepts a read after a random delay, answers it after one to three cycles and then goes quiet until the next accepted read. The stimulus also keeps new requests away from the idle cycle that follows a result, except where a request during a walk is applied on purpose to show that it is ignored.

// File: rtl/pt_walk_pkg.sv
// Package pt_walk_pkg
// Shared constants and types for the page table walker.
// Assumes the entry layout described in the brief (valid bit 0, leaf bit 7).
package pt_walk_pkg;
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_LEAF_BIT  = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } walk_state_e;
endpackage

// File: rtl/pt_va_split.sv
// Module pt_va_split
// Slices the per-level table indices out of a virtual address and checks
// that the unused upper bits are a sign extension of the top used bit.
// Assumes PG_SHIFT + LEVELS*IDX_W <= VA_W.
module pt_va_split #(
    parameter int VA_W     = 64,
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int PG_SHIFT = 12
) (
    input  logic [VA_W-1:0]               va_i,
    output logic [LEVELS-1:0][IDX_W-1:0]  idx_o,
    output logic                          canonical_o
);
    localparam int TOP_BIT = PG_SHIFT + LEVELS*IDX_W - 1;

    // One index field per level, level 0 being the bottom table.
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_idx
        assign idx_o[lv] = va_i[PG_SHIFT + lv*IDX_W +: IDX_W];
    end

    // Sign-extension test over the bits above the translated range.
    if (TOP_BIT == VA_W-1) begin : g_no_ext
        assign canonical_o = 1'b1;
    end else begin : g_ext
        assign canonical_o = (&va_i[VA_W-1:TOP_BIT]) | ~(|va_i[VA_W-1:TOP_BIT]);
    end

    logic unused_offset_bits;
    assign unused_offset_bits = ^va_i[PG_SHIFT-1:0];
endmodule

// File: rtl/pt_entry_decode.sv
// Module pt_entry_decode
// Decodes one table entry read at a given level: validity, leaf status,
// embedded page number and whether a large frame is misaligned.
// Assumes level 0 is the bottom table where every valid entry is a leaf.
module pt_entry_decode
    import pt_walk_pkg::*;
#(
    parameter int PTE_W    = 64,
    parameter int PA_W     = 52,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 9,
    parameter int LVL_W    = 2
) (
    input  logic [PTE_W-1:0]           pte_i,
    input  logic [LVL_W-1:0]           lvl_i,
    output logic                       valid_o,
    output logic                       leaf_o,
    output logic [PA_W-PG_SHIFT-1:0]   ppn_o,
    output logic                       misaligned_o
);
    localparam int PPN_W = PA_W - PG_SHIFT;

    logic [PPN_W-1:0] low_mask;

    // Field extraction from the raw entry.
    assign valid_o = pte_i[PTE_VALID_BIT];
    assign ppn_o   = pte_i[PG_SHIFT +: PPN_W];
    assign leaf_o  = (lvl_i == '0) | pte_i[PTE_LEAF_BIT];

    // Page-number bits that a frame at this level must leave clear.
    always_comb begin
        low_mask = ~({PPN_W{1'b1}} << (int'(lvl_i) * IDX_W));
    end

    assign misaligned_o = |(ppn_o & low_mask);

    logic unused_pte_bits;
    assign unused_pte_bits = ^{pte_i[PTE_W-1:PA_W], pte_i[PG_SHIFT-1:PTE_LEAF_BIT+1],
                               pte_i[PTE_LEAF_BIT-1:PTE_VALID_BIT+1]};
endmodule

// File: rtl/pt_pa_compose.sv
// Module pt_pa_compose
// Builds the physical address from a frame page number and the virtual
// address offset whose width depends on the leaf level.
// Assumes the frame page number is aligned to the page size at that level.
module pt_pa_compose #(
    parameter int PA_W     = 52,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 9,
    parameter int LVL_W    = 2
) (
    input  logic [PA_W-1:0]           va_low_i,
    input  logic [PA_W-PG_SHIFT-1:0]  ppn_i,
    input  logic [LVL_W-1:0]          lvl_i,
    output logic [PA_W-1:0]           pa_o
);
    logic [PA_W-1:0] off_mask;

    // Offset mask widens by one index field per level above the bottom.
    always_comb begin
        off_mask = ~({PA_W{1'b1}} << (PG_SHIFT + int'(lvl_i) * IDX_W));
        pa_o     = ({ppn_i, {PG_SHIFT{1'b0}}} & ~off_mask) | (va_low_i & off_mask);
    end
endmodule

// File: rtl/pt_walk_top.sv
// Module pt_walk_top
// Sequential four-level page table walker. Takes one translation at a time,
// issues one entry read per level, stops at the first leaf and reports
// frame, size code, physical address or a fault as a one-cycle pulse.
// Assumes one response pulse per accepted read and none otherwise.
module pt_walk_top
    import pt_walk_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PA_W     = 52,
    parameter int PTE_W    = 64,
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    output logic                          req_ready_o,
    input  logic [VA_W-1:0]               req_va_i,
    input  logic [PA_W-IDX_W-4:0]         root_ppn_i,
    output logic                          mem_req_valid_o,
    input  logic                          mem_req_ready_i,
    output logic [PA_W-1:0]               mem_req_addr_o,
    input  logic                          mem_rsp_valid_i,
    input  logic [PTE_W-1:0]              mem_rsp_data_i,
    output logic                          done_valid_o,
    output logic                          done_fault_o,
    output logic [$clog2(LEVELS)-1:0]     done_size_o,
    output logic [PA_W-IDX_W-4:0]         done_ppn_o,
    output logic [PA_W-1:0]               done_pa_o
);
    localparam int ENTRY_SHIFT = $clog2(PTE_W/8);
    localparam int PG_SHIFT    = IDX_W + ENTRY_SHIFT;
    localparam int PPN_W       = PA_W - PG_SHIFT;
    localparam int LVL_W       = $clog2(LEVELS);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS-1);
    localparam int CANON_BIT   = PG_SHIFT + LEVELS*IDX_W - 1;

    walk_state_e             state_q;
    logic [LVL_W-1:0]        lvl_q;
    logic [VA_W-1:0]         va_q;
    logic [PA_W-1:0]         addr_q;
    logic                    res_fault_q;
    logic [LVL_W-1:0]        res_size_q;
    logic [PPN_W-1:0]        res_ppn_q;
    logic [PA_W-1:0]         res_pa_q;

    logic [VA_W-1:0]               split_va;
    logic [LEVELS-1:0][IDX_W-1:0]  split_idx;
    logic                          split_canon;
    logic                          ent_valid, ent_leaf, ent_misal;
    logic [PPN_W-1:0]              ent_ppn;
    logic [PA_W-1:0]               leaf_pa;

    // Index source: incoming address while idle, held address during a walk.
    assign split_va = (state_q == ST_IDLE) ? req_va_i : va_q;

    pt_va_split #(.VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT)) u_split (
        .va_i(split_va), .idx_o(split_idx), .canonical_o(split_canon)
    );

    pt_entry_decode #(.PTE_W(PTE_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
                      .LVL_W(LVL_W)) u_dec (
        .pte_i(mem_rsp_data_i), .lvl_i(lvl_q), .valid_o(ent_valid), .leaf_o(ent_leaf),
        .ppn_o(ent_ppn), .misaligned_o(ent_misal)
    );

    pt_pa_compose #(.PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_pa (
        .va_low_i(va_q[PA_W-1:0]), .ppn_i(ent_ppn), .lvl_i(lvl_q), .pa_o(leaf_pa)
    );

    // Walk sequencer: accept, request, wait for entry, descend or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lvl_q       <= '0;
            va_q        <= '0;
            addr_q      <= '0;
            res_fault_q <= 1'b0;
            res_size_q  <= '0;
            res_ppn_q   <= '0;
            res_pa_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        va_q        <= req_va_i;
                        res_fault_q <= 1'b0;
                        res_size_q  <= '0;
                        res_ppn_q   <= '0;
                        res_pa_q    <= '0;
                        if (!split_canon) begin
                            res_fault_q <= 1'b1;
                            state_q     <= ST_DONE;
                        end else begin
                            lvl_q   <= TOP_LVL;
                            addr_q  <= {root_ppn_i, split_idx[LEVELS-1], {ENTRY_SHIFT{1'b0}}};
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready_i) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid_i) begin
                        if (!ent_valid) begin
                            res_fault_q <= 1'b1;
                            state_q     <= ST_DONE;
                        end else if (ent_leaf) begin
                            state_q <= ST_DONE;
                            if (lvl_q == TOP_LVL || ent_misal) begin
                                res_fault_q <= 1'b1;
                            end else begin
                                res_size_q <= lvl_q;
                                res_ppn_q  <= ent_ppn;
                                res_pa_q   <= leaf_pa;
                            end
                        end else begin
                            lvl_q   <= lvl_q - 1'b1;
                            addr_q  <= {ent_ppn, split_idx[lvl_q - 1'b1], {ENTRY_SHIFT{1'b0}}};
                            state_q <= ST_REQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready_o     = (state_q == ST_IDLE);
    assign mem_req_valid_o = (state_q == ST_REQ);
    assign mem_req_addr_o  = addr_q;
    assign done_valid_o    = (state_q == ST_DONE);
    assign done_fault_o    = res_fault_q;
    assign done_size_o     = res_size_q;
    assign done_ppn_o      = res_ppn_q;
    assign done_pa_o       = res_pa_q;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
    // R4
    no_req_during_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid_i |-> !mem_req_valid_o);
    // R3
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> mem_req_addr_o[ENTRY_SHIFT-1:0] == '0);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid_o |=> !done_valid_o && req_ready_o);
    // R9
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid_o && done_fault_o |-> done_pa_o == '0 && done_ppn_o == '0 && done_size_o == '0);
    // R6
    size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid_o && !done_fault_o |-> done_size_o != TOP_LVL);
    // R2
    noncanon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o &&
        !((&req_va_i[VA_W-1:CANON_BIT]) || !(|req_va_i[VA_W-1:CANON_BIT]))
        |=> done_valid_o && done_fault_o);
endmodule

// File: tb/pt_walk_top_tb_top.sv
`timescale 1ns/1ps
module pt_walk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [63:0] req_va;
    logic [39:0] root_ppn;
    logic        mem_req_ready;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        req_ready_o, mem_req_valid_o, done_valid_o, done_fault_o;
    logic [51:0] mem_req_addr_o, done_pa_o;
    logic [1:0]  done_size_o;
    logic [39:0] done_ppn_o;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int cycles = 0;
    logic [63:0] pmem [logic [51:0]];

    always #2.5 clk = ~clk;

    pt_walk_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
        .req_va_i(req_va), .root_ppn_i(root_ppn), .mem_req_valid_o(mem_req_valid_o),
        .mem_req_ready_i(mem_req_ready), .mem_req_addr_o(mem_req_addr_o),
        .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
        .done_valid_o(done_valid_o), .done_fault_o(done_fault_o), .done_size_o(done_size_o),
        .done_ppn_o(done_ppn_o), .done_pa_o(done_pa_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [51:0] a);
        return pmem.exists(a) ? pmem[a] : 64'h0;
    endfunction

    // Reference walk computed from the requirements.
    function automatic void ref_walk(input logic [63:0] va, input logic [39:0] root,
            output bit flt, output logic [1:0] sz, output logic [51:0] pa,
            output logic [39:0] ppn, output int n);
        logic [39:0] tbl;
        logic [63:0] e;
        logic [51:0] m;
        flt = 0; sz = 0; pa = 0; ppn = 0; n = 0;
        if (va[63:47] != '0 && va[63:47] != '1) begin flt = 1; return; end
        tbl = root;
        for (int l = 3; l >= 0; l--) begin
            e = rd({tbl, va[12+9*l +: 9], 3'b000});
            n++;
            if (!e[0]) begin flt = 1; return; end
            if (l == 0 || e[7]) begin
                if (l == 3 || (l > 0 && (e[51:12] & ((40'd1 << (9*l)) - 1)) != 0)) begin
                    flt = 1; return;
                end
                m   = (52'd1 << (12 + 9*l)) - 1;
                sz  = 2'(l);
                ppn = e[51:12];
                pa  = ({e[51:12], 12'h000} & ~m) | (va[51:0] & m);
                return;
            end
            tbl = e[51:12];
        end
    endfunction

    function automatic logic [39:0] rnd40();
        return {8'($urandom), $urandom};
    endfunction

    // Fill memory with one walk path; bad < 0 means no invalid entry.
    task automatic build(input logic [63:0] va, input logic [39:0] root, input int leaf,
                         input int bad, input bit l4leaf, input bit misal);
        logic [39:0] tbl, nxt, fr;
        logic [63:0] e;
        logic [51:0] a;
        pmem.delete();
        tbl = root;
        for (int l = 3; l >= 0; l--) begin
            a = {tbl, va[12+9*l +: 9], 3'b000};
            if (l == leaf || (l4leaf && l == 3)) begin
                fr = rnd40();
                if (l > 0) fr = fr & ~((40'd1 << (9*l)) - 1);
                if (misal && l > 0) fr[0] = 1'b1;
                e = {12'h0, fr, 12'h001};
                if (l > 0 || $urandom % 2 == 1) e[7] = 1'b1;
                if (l == bad) e[0] = 1'b0;
                pmem[a] = e;
                break;
            end
            nxt = rnd40();
            e = {12'h0, nxt, 12'h001} | (64'($urandom % 64) << 1);
            if (l == bad) e[0] = 1'b0;
            pmem[a] = e;
            if (l == bad) break;
            tbl = nxt;
        end
    endtask

    // Memory model: random accept delay, response 1..3 cycles later.
    initial begin
        int dly = 0;
        bit rq = 0;
        logic [51:0] cap = '0;
        logic [63:0] dat = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (rq) begin
                rq = 0; mem_req_ready = 0; reads++;
                if (mem_req_addr_o != cap) chk(1'b0, "R4 address moved", 64'(mem_req_addr_o), 64'(cap));
                dat = rd(cap);
                dly = 1 + int'($urandom % 3);
            end else if (dly > 0) begin
                if (mem_req_valid_o) chk(1'b0, "R4 second read outstanding", 1, 0);
                dly--;
                if (dly == 0) begin mem_rsp_valid = 1; mem_rsp_data = dat; end
            end else if (mem_req_valid_o && ($urandom % 2 == 1)) begin
                cap = mem_req_addr_o; mem_req_ready = 1; rq = 1;
            end
        end
    end

    // One translation: drive, wait for the pulse, compare with the model.
    task automatic run_case(input logic [63:0] va, input logic [39:0] root,
                            input string tag, input bit poke);
        bit eflt; logic [1:0] esz; logic [51:0] epa; logic [39:0] eppn; int en;
        int n = 0;
        ref_walk(va, root, eflt, esz, epa, eppn, en);
        reads = 0;
        @(negedge clk);
        chk(req_ready_o == 1'b1, "R9 idle ready", 64'(req_ready_o), 1);
        req_valid = 1; req_va = va; root_ppn = root;
        @(negedge clk);
        req_valid = 0;
        if (!done_valid_o) chk(req_ready_o == 1'b0, "R9 busy not ready", 64'(req_ready_o), 0);
        if (poke && !done_valid_o) begin
            req_valid = 1; req_va = ~va; root_ppn = ~root;
            @(negedge clk); n++;
            @(negedge clk); n++;
            req_valid = 0;
        end
        while (!done_valid_o && n < 400) begin @(negedge clk); n++; end
        if (!eflt && va[63:47] != '0 && va[63:47] != '1) chk(1'b0, "R2 model", 0, 1);
        chk(done_valid_o == 1'b1, {tag, " done seen"}, 64'(done_valid_o), 1);
        chk(done_fault_o == eflt, {tag, " fault"}, 64'(done_fault_o), 64'(eflt));
        chk(done_size_o == esz, {tag, " size R6"}, 64'(done_size_o), 64'(esz));
        chk(done_pa_o == epa, {tag, " pa R6"}, 64'(done_pa_o), 64'(epa));
        chk(done_ppn_o == eppn, {tag, " ppn R10"}, 64'(done_ppn_o), 64'(eppn));
        chk(reads == en, {tag, " read count R3/R5"}, 64'(reads), 64'(en));
        if (en == 0) chk(n == 0, "R2 result next cycle", 64'(n), 0);
        @(negedge clk);
        chk(done_valid_o == 1'b0, "R9 single pulse", 64'(done_valid_o), 0);
        chk(mem_req_valid_o == 1'b0, "R9 no stray walk", 64'(mem_req_valid_o), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] va;
        logic [39:0] rt;
        void'($urandom(32'd1234));
        rst_n = 0; req_valid = 0; req_va = '0; root_ppn = '0;
        repeat (3) @(negedge clk);
        chk(req_ready_o == 1'b1, "R1 ready", 64'(req_ready_o), 1);
        chk(mem_req_valid_o == 1'b0, "R1 mem idle", 64'(mem_req_valid_o), 0);
        chk(done_valid_o == 1'b0, "R1 no done", 64'(done_valid_o), 0);
        rst_n = 1;

        // Directed corners.
        va = 64'h0000_1234_5678_9ABC; rt = 40'h12_3456_789A;
        build(va, rt, 0, -1, 0, 0); run_case(va, rt, "R6 4K leaf", 0);
        build(va, rt, 1, -1, 0, 0); run_case(va, rt, "R6 2M leaf", 0);
        build(va, rt, 2, -1, 0, 0); run_case(va, rt, "R6 1G leaf", 0);
        va = 64'hFFFF_8000_0040_1FF8;
        build(va, rt, 0, -1, 0, 0); run_case(va, rt, "R6 upper-half VA", 0);
        va = 64'h7FFF_8000_0000_0000;
        build(va, rt, 0, -1, 0, 0); run_case(va, rt, "R2 non-canonical", 0);
        va = 64'h0000_7ABC_DEF0_1234;
        build(va, rt, 0, 3, 0, 0); run_case(va, rt, "R7 invalid at top", 0);
        build(va, rt, 0, 0, 0, 0); run_case(va, rt, "R7 invalid at bottom", 0);
        build(va, rt, 0, -1, 1, 0); run_case(va, rt, "R7 leaf at top", 0);
        build(va, rt, 1, -1, 0, 1); run_case(va, rt, "R8 misaligned 2M", 0);
        build(va, rt, 2, -1, 0, 1); run_case(va, rt, "R8 misaligned 1G", 0);
        build(va, rt, 0, -1, 0, 0); run_case(va, rt, "R9 request while busy", 1);

        // Constrained random walks.
        for (int i = 0; i < 400; i++) begin
            int kind, leaf;
            va = {$urandom, $urandom};
            va[63:48] = {16{va[47]}};
            rt = rnd40();
            kind = int'($urandom % 10);
            leaf = int'($urandom % 3);
            if (kind == 3) va[63] = ~va[47];
            build(va, rt, leaf, (kind == 0) ? leaf + int'($urandom % (4 - leaf)) : -1,
                  kind == 2, kind == 1);
            run_case(va, rt, "R5 random walk", kind == 4);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule